// File: doc/BRIEF.md
# Sharing-List Cache Line Controller

This block manages one cache line that takes part in a distributed, doubly linked list of sharers. The line keeps its own place in the list (sole member, first, interior or last), the state of its data, and two node identifiers. The forward pointer names the next sharer, toward the end of the list. The backward pointer names the previous sharer, toward the front. No central structure holds the list. Each member knows only its two neighbours.

A read or write miss asks memory to join the list. Memory answers with the identifier of the current front member, if there is one. The line then places itself at the front and sends a link message to the old front member. A write by a line that shares the block with others first makes that line the front member. It then invalidates the other members one at a time: each one it reaches replies with its own forward pointer, and that pointer becomes the next target. The same line also serves link and invalidate messages that come from other nodes. While a join or an invalidation walk is running, new processor requests are held off.

Top module: `shlist_line_ctrl`

## Requirements
- R1: After reset the line is invalid (data code 0) and sole member (position code 0), with both pointers null. The processor port is ready, and no memory or peer message is offered.
- R2: A read when the data code is not 0 completes on the next cycle with no message sent. A write when the position is sole member does the same and sets the data to Modified (code 4).
- R3: A miss raises a memory request whose write flag shows the kind of access. If the answer names no front member, the line becomes sole member with data Clean (code 1) on a read, or Modified (code 4) on a write.
- R4: If a read miss's answer names a front member h, the line sends a link message (kind 0) to h carrying its own id. It then becomes first (position 1) with data Fresh (code 2), forward pointer h and backward pointer null.
- R5: A link message from node s sets the backward pointer to s. It turns first (1) into interior (2) and sole (0) into last (3), and turns Clean into Valid (code 3). Other data codes are kept. An invalid line ignores the message.
- R6: An invalidate message (kind 1) from s is answered with an acknowledge (kind 2) to s. The acknowledge carries the line's forward pointer and that pointer's valid flag. The line then becomes invalid, sole member, with both pointers cleared.
- R7: A write by the first member sends an invalidate to its forward pointer. Each acknowledge's pointer names the next target. An acknowledge with a null pointer ends the walk, leaving the line sole member and Modified with both pointers null.
- R8: A write miss that receives a front member links to it as in R4, then runs the walk of R7. No further memory request is made.
- R9: A write by an interior or last member joins again through memory. If an acknowledge then names the line itself, the walk continues with the forward pointer the line held before joining again.
- R10: From the acceptance of a request that needs memory or peers until its completion pulse, the processor port is not ready.
- R11: An offered peer message holds its kind, destination and pointer unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid |
| cpu_done | output | 1 | One-cycle completion pulse |
| mem_req_valid | output | 1 | Join request to memory |
| mem_req_write | output | 1 | Join is for a write |
| mem_req_ready | input | 1 | Memory accepts the join request |
| mem_rsp_valid | input | 1 | Memory answer present |
| mem_rsp_head_vld | input | 1 | Answer names a current front member |
| mem_rsp_head | input | NODE_W | Id of the current front member |
| po_valid | output | 1 | Outgoing peer message offered |
| po_kind | output | 2 | 0 link, 1 invalidate, 2 acknowledge |
| po_dst | output | NODE_W | Destination node |
| po_ptr_vld | output | 1 | Pointer field is valid |
| po_ptr | output | NODE_W | Pointer field (own id or forward pointer) |
| po_ready | input | 1 | Network accepts the outgoing message |
| pi_valid | input | 1 | Incoming peer message present |
| pi_kind | input | 2 | 0 link, 1 invalidate, 2 acknowledge |
| pi_src | input | NODE_W | Sending node |
| pi_ptr_vld | input | 1 | Incoming pointer valid |
| pi_ptr | input | NODE_W | Incoming pointer |
| pi_ready | output | 1 | Incoming message accepted |
| line_pos | output | 2 | List position code |
| line_data | output | 3 | Data state code |
| fwd_vld | output | 1 | Forward pointer valid |
| fwd_id | output | NODE_W | Forward (next) node |
| bwd_vld | output | 1 | Backward pointer valid |
| bwd_id | output | NODE_W | Backward (previous) node |

## Verification
The bench builds the block with NODE_W = 4 and SELF_ID = 5. The 4-bit id space allows front members at both ends of the range (ids 0 and 15). It also allows invalidation chains of up to three remote nodes that never collide with the line's own id. The non-zero SELF_ID allows a chain to be routed through node 5 on purpose, which exercises the case where a line that joined again meets its own old place in the list and skips past it.

// File: rtl/shlist_line_ctrl.sv
`timescale 1ns/1ps
module shlist_line_ctrl #(
  parameter int NODE_W  = 4,
  parameter int SELF_ID = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  output logic              cpu_req_ready,
  output logic              cpu_done,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_head_vld,
  input  logic [NODE_W-1:0] mem_rsp_head,
  output logic              po_valid,
  output logic [1:0]        po_kind,
  output logic [NODE_W-1:0] po_dst,
  output logic              po_ptr_vld,
  output logic [NODE_W-1:0] po_ptr,
  input  logic              po_ready,
  input  logic              pi_valid,
  input  logic [1:0]        pi_kind,
  input  logic [NODE_W-1:0] pi_src,
  input  logic              pi_ptr_vld,
  input  logic [NODE_W-1:0] pi_ptr,
  output logic              pi_ready,
  output logic [1:0]        line_pos,
  output logic [2:0]        line_data,
  output logic              fwd_vld,
  output logic [NODE_W-1:0] fwd_id,
  output logic              bwd_vld,
  output logic [NODE_W-1:0] bwd_id
);
  localparam logic [NODE_W-1:0] SELF = SELF_ID[NODE_W-1:0];

  localparam logic [1:0] P_ONLY = 2'd0;
  localparam logic [1:0] P_HEAD = 2'd1;
  localparam logic [1:0] P_MID  = 2'd2;
  localparam logic [1:0] P_TAIL = 2'd3;

  localparam logic [2:0] D_INV   = 3'd0;
  localparam logic [2:0] D_CLEAN = 3'd1;
  localparam logic [2:0] D_FRESH = 3'd2;
  localparam logic [2:0] D_VALID = 3'd3;
  localparam logic [2:0] D_MOD   = 3'd4;

  localparam logic [1:0] K_LINK = 2'd0;
  localparam logic [1:0] K_INV  = 2'd1;
  localparam logic [1:0] K_ACK  = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_MREQ, S_MRSP, S_LINK, S_INVTX, S_INVRX} st_t;

  st_t               st;
  logic [1:0]        pos;
  logic [2:0]        dat;
  logic              fv, bv;
  logic [NODE_W-1:0] fid, bid;
  logic              wr_q;
  logic              sv_v;
  logic [NODE_W-1:0] sv_id;
  logic              po_v, po_pv;
  logic [1:0]        po_k;
  logic [NODE_W-1:0] po_d, po_p;
  logic              done_q;

  logic              idle, cpu_fire, po_fire, pi_fire, ack_self, nx_v;
  logic [NODE_W-1:0] nx_id;

  assign idle     = (st == S_IDLE);
  assign pi_ready = (pi_kind == K_LINK && idle) ||
                    (pi_kind == K_INV  && idle && !po_v) ||
                    (pi_kind == K_ACK  && st == S_INVRX) ||
                    (pi_kind == 2'd3);
  assign cpu_req_ready = idle && !po_v && !pi_valid;
  assign cpu_fire = cpu_req_valid && cpu_req_ready;
  assign po_fire  = po_v && po_ready;
  assign pi_fire  = pi_valid && pi_ready;
  assign ack_self = pi_ptr_vld && (pi_ptr == SELF);
  assign nx_v     = ack_self ? sv_v  : pi_ptr_vld;
  assign nx_id    = ack_self ? sv_id : pi_ptr;

  assign mem_req_valid = (st == S_MREQ);
  assign mem_req_write = wr_q;
  assign po_valid   = po_v;
  assign po_kind    = po_k;
  assign po_dst     = po_d;
  assign po_ptr_vld = po_pv;
  assign po_ptr     = po_p;
  assign cpu_done   = done_q;
  assign line_pos   = pos;
  assign line_data  = dat;
  assign fwd_vld    = fv;
  assign fwd_id     = fid;
  assign bwd_vld    = bv;
  assign bwd_id     = bid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pos    <= P_ONLY;
      dat    <= D_INV;
      fv     <= 1'b0;
      bv     <= 1'b0;
      fid    <= '0;
      bid    <= '0;
      wr_q   <= 1'b0;
      sv_v   <= 1'b0;
      sv_id  <= '0;
      po_v   <= 1'b0;
      po_k   <= K_LINK;
      po_d   <= '0;
      po_pv  <= 1'b0;
      po_p   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (po_fire) po_v <= 1'b0;
      case (st)
        S_IDLE: begin
          if (pi_fire && pi_kind == K_LINK) begin
            if (dat != D_INV) begin
              bv  <= 1'b1;
              bid <= pi_src;
              if (pos == P_ONLY) pos <= P_TAIL;
              else if (pos == P_HEAD) pos <= P_MID;
              if (dat == D_CLEAN) dat <= D_VALID;
            end
          end else if (pi_fire && pi_kind == K_INV) begin
            po_v  <= 1'b1;
            po_k  <= K_ACK;
            po_d  <= pi_src;
            po_pv <= fv;
            po_p  <= fid;
            dat   <= D_INV;
            pos   <= P_ONLY;
            fv    <= 1'b0;
            bv    <= 1'b0;
          end else if (cpu_fire) begin
            wr_q <= cpu_req_write;
            if (dat == D_INV) begin
              sv_v <= 1'b0;
              st   <= S_MREQ;
            end else if (!cpu_req_write) begin
              done_q <= 1'b1;
            end else if (pos == P_ONLY) begin
              dat    <= D_MOD;
              done_q <= 1'b1;
            end else if (pos == P_HEAD) begin
              po_v  <= 1'b1;
              po_k  <= K_INV;
              po_d  <= fid;
              po_pv <= 1'b0;
              st    <= S_INVTX;
            end else begin
              sv_v  <= fv;
              sv_id <= fid;
              st    <= S_MREQ;
            end
          end
        end
        S_MREQ: if (mem_req_ready) st <= S_MRSP;
        S_MRSP: begin
          if (mem_rsp_valid) begin
            bv <= 1'b0;
            if (!mem_rsp_head_vld) begin
              pos    <= P_ONLY;
              fv     <= 1'b0;
              dat    <= wr_q ? D_MOD : D_CLEAN;
              done_q <= 1'b1;
              st     <= S_IDLE;
            end else begin
              pos   <= P_HEAD;
              fv    <= 1'b1;
              fid   <= mem_rsp_head;
              dat   <= D_FRESH;
              po_v  <= 1'b1;
              po_k  <= K_LINK;
              po_d  <= mem_rsp_head;
              po_pv <= 1'b1;
              po_p  <= SELF;
              st    <= S_LINK;
            end
          end
        end
        S_LINK: begin
          if (po_fire) begin
            if (wr_q) begin
              po_v  <= 1'b1;
              po_k  <= K_INV;
              po_d  <= fid;
              po_pv <= 1'b0;
              st    <= S_INVTX;
            end else begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end
          end
        end
        S_INVTX: if (po_fire) st <= S_INVRX;
        S_INVRX: begin
          if (pi_fire && pi_kind == K_ACK) begin
            if (ack_self) sv_v <= 1'b0;
            if (nx_v) begin
              fid   <= nx_id;
              po_v  <= 1'b1;
              po_k  <= K_INV;
              po_d  <= nx_id;
              po_pv <= 1'b0;
              st    <= S_INVTX;
            end else begin
              pos    <= P_ONLY;
              dat    <= D_MOD;
              fv     <= 1'b0;
              bv     <= 1'b0;
              done_q <= 1'b1;
              st     <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_hit_local: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready && !cpu_req_write && dat != D_INV
    |=> cpu_done && !mem_req_valid && !po_valid);

  a_r5_link_demotes_head: assert property (@(posedge clk) disable iff (!rst_n)
    pi_valid && pi_ready && pi_kind == K_LINK && dat != D_INV && pos == P_HEAD
    |=> pos == P_MID && bv && bid == $past(pi_src));

  a_r6_inv_reply: assert property (@(posedge clk) disable iff (!rst_n)
    pi_valid && pi_ready && pi_kind == K_INV
    |=> po_valid && po_kind == K_ACK && po_dst == $past(pi_src) && dat == D_INV);

  a_r7_walk_end: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_INVRX && pi_valid && pi_kind == K_ACK && !pi_ptr_vld
    |=> pos == P_ONLY && dat == D_MOD && cpu_done && !fv);

  a_r10_stall_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready && dat == D_INV |=> !cpu_req_ready);

  a_r11_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    po_valid && !po_ready
    |=> po_valid && $stable(po_kind) && $stable(po_dst) && $stable(po_ptr) && $stable(po_ptr_vld));
endmodule

// File: tb/shlist_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module shlist_line_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int SELF = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_req_valid, cpu_req_write, cpu_req_ready, cpu_done;
  logic mem_req_valid, mem_req_write, mem_req_ready;
  logic mem_rsp_valid, mem_rsp_head_vld;
  logic [NW-1:0] mem_rsp_head;
  logic po_valid, po_ptr_vld, po_ready;
  logic [1:0] po_kind;
  logic [NW-1:0] po_dst, po_ptr;
  logic pi_valid, pi_ptr_vld, pi_ready;
  logic [1:0] pi_kind;
  logic [NW-1:0] pi_src, pi_ptr;
  logic [1:0] line_pos;
  logic [2:0] line_data;
  logic fwd_vld, bwd_vld;
  logic [NW-1:0] fwd_id, bwd_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  shlist_line_ctrl #(.NODE_W(NW), .SELF_ID(SELF)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_ready(cpu_req_ready), .cpu_done(cpu_done),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_head_vld(mem_rsp_head_vld), .mem_rsp_head(mem_rsp_head),
    .po_valid(po_valid), .po_kind(po_kind), .po_dst(po_dst), .po_ptr_vld(po_ptr_vld),
    .po_ptr(po_ptr), .po_ready(po_ready),
    .pi_valid(pi_valid), .pi_kind(pi_kind), .pi_src(pi_src), .pi_ptr_vld(pi_ptr_vld),
    .pi_ptr(pi_ptr), .pi_ready(pi_ready),
    .line_pos(line_pos), .line_data(line_data),
    .fwd_vld(fwd_vld), .fwd_id(fwd_id), .bwd_vld(bwd_vld), .bwd_id(bwd_id)
  );

  // wr, head_vld, head, len, exp_pos, exp_data, exp_fwd_vld, exp_links, exp_invs, exp_mem_wr, spare
  localparam logic [19:0] VEC [7] = '{
    {1'b0, 1'b0, 4'd0,  2'd0, 2'd0, 3'd1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd8,  2'd0, 2'd1, 3'd2, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd15, 2'd0, 2'd1, 3'd2, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0},
    {1'b1, 1'b0, 4'd0,  2'd0, 2'd0, 3'd4, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0},
    {1'b1, 1'b1, 4'd8,  2'd1, 2'd0, 3'd4, 1'b0, 1'b1, 3'd1, 1'b1, 1'b0},
    {1'b1, 1'b1, 4'd10, 2'd3, 2'd0, 3'd4, 1'b0, 1'b1, 3'd3, 1'b1, 1'b0},
    {1'b1, 1'b1, 4'd0,  2'd2, 2'd0, 3'd4, 1'b0, 1'b1, 3'd2, 1'b1, 1'b0}
  };

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  logic          nxv [16];
  logic [NW-1:0] nxi [16];
  logic          mhv;
  logic [NW-1:0] mhead;

  int link_cnt, inv_cnt, mreq_cnt, stall_bad, last_link, last_inv, mreq_wr;
  bit done_seen;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < 16; k++) begin
      nxv[k] = 1'b0;
      nxi[k] = '0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cpu_req_valid = 0; cpu_req_write = 0; mem_req_ready = 1;
    mem_rsp_valid = 0; mem_rsp_head_vld = 0; mem_rsp_head = '0;
    po_ready = 1; pi_valid = 0; pi_kind = 2'd0; pi_src = '0; pi_ptr_vld = 0; pi_ptr = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_op(input bit wr);
    bit rsp_due, ack_due, drop;
    logic [NW-1:0] ack_src;
    rsp_due = 0; ack_due = 0; drop = 0; ack_src = '0;
    link_cnt = 0; inv_cnt = 0; mreq_cnt = 0; stall_bad = 0;
    last_link = -1; last_inv = -1; mreq_wr = -1; done_seen = 0;
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = wr;
    for (int i = 0; i < 100 && !done_seen; i++) begin
      mem_rsp_valid = rsp_due; mem_rsp_head_vld = mhv; mem_rsp_head = mhead; rsp_due = 0;
      pi_valid = ack_due; pi_kind = 2'd2; pi_src = ack_src;
      pi_ptr_vld = nxv[ack_src]; pi_ptr = nxi[ack_src]; ack_due = 0;
      if (drop) cpu_req_valid = 0;
      #1;
      if (cpu_done) done_seen = 1;
      if (drop && !cpu_done && cpu_req_ready) stall_bad++;
      if (cpu_req_valid && cpu_req_ready) drop = 1;
      if (mem_req_valid) begin mreq_cnt++; mreq_wr = mem_req_write; rsp_due = 1; end
      if (po_valid && po_kind == 2'd0) begin link_cnt++; last_link = po_dst; end
      if (po_valid && po_kind == 2'd1) begin inv_cnt++; last_inv = po_dst; ack_due = 1; ack_src = po_dst; end
      if (!done_seen) @(negedge clk);
    end
    cpu_req_valid = 0; pi_valid = 0; mem_rsp_valid = 0;
  endtask

  task automatic send_pi(input logic [1:0] kind, input logic [NW-1:0] src);
    @(negedge clk);
    pi_valid = 1; pi_kind = kind; pi_src = src; pi_ptr_vld = 0; pi_ptr = '0;
    @(negedge clk);
    pi_valid = 0;
  endtask

  task automatic join_read(input logic [NW-1:0] h, input logic hv);
    do_reset();
    clear_model();
    mhv = hv; mhead = h;
    run_op(1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    mhv = 0; mhead = '0;
    clear_model();
    do_reset();
    #1;
    chk("R1 pos", line_pos, 0);
    chk("R1 data", line_data, 0);
    chk("R1 fwd", fwd_vld, 0);
    chk("R1 bwd", bwd_vld, 0);
    chk("R1 ready", cpu_req_ready, 1);
    chk("R1 po", po_valid, 0);
    chk("R1 mem", mem_req_valid, 0);

    for (int v = 0; v < 7; v++) begin
      logic [19:0] e;
      e = VEC[v];
      do_reset();
      clear_model();
      mhv = e[18]; mhead = e[17:14];
      for (int k = 0; k < int'(e[13:12]); k++) begin
        if (k < int'(e[13:12]) - 1) begin
          nxv[e[17:14] + k] = 1'b1;
          nxi[e[17:14] + k] = e[17:14] + k + 1;
        end
      end
      run_op(e[19]);
      chk("R3 done", done_seen, 1);
      chk("R3 mem write flag", mreq_wr, e[1]);
      chk("R3 pos", line_pos, e[11:10]);
      chk("R3 data", line_data, e[9:7]);
      chk("R4 fwd vld", fwd_vld, e[6]);
      if (e[6]) chk("R4 fwd id", fwd_id, e[17:14]);
      chk("R4 bwd null", bwd_vld, 0);
      chk("R4 links", link_cnt, e[5]);
      if (e[5]) chk("R4 link dst", last_link, e[17:14]);
      chk("R8 invalidates", inv_cnt, e[4:2]);
      chk("R10 stall", stall_bad, 0);
    end

    // R2 hits
    join_read(4'd0, 1'b0);
    run_op(1'b0);
    chk("R2 read hit done", done_seen, 1);
    chk("R2 read hit mem", mreq_cnt, 0);
    chk("R2 read hit msgs", link_cnt + inv_cnt, 0);
    run_op(1'b1);
    chk("R2 write hit mem", mreq_cnt, 0);
    chk("R2 write hit data", line_data, 4);
    chk("R2 write hit pos", line_pos, 0);

    // R5 link on sole Modified: Tail, data kept
    send_pi(2'd0, 4'd3);
    chk("R5 only->tail", line_pos, 3);
    chk("R5 bwd set", bwd_vld, 1);
    chk("R5 bwd id", bwd_id, 3);
    chk("R5 modified kept", line_data, 4);

    // R5 Clean -> Valid
    join_read(4'd0, 1'b0);
    send_pi(2'd0, 4'd2);
    chk("R5 clean->valid", line_data, 3);
    chk("R5 tail", line_pos, 3);

    // R5 invalid line ignores link
    do_reset();
    send_pi(2'd0, 4'd4);
    chk("R5 invalid ignores bwd", bwd_vld, 0);
    chk("R5 invalid ignores pos", line_pos, 0);

    // R7 head write walk
    join_read(4'd8, 1'b1);
    nxv[8] = 1; nxi[8] = 4'd9;
    run_op(1'b1);
    chk("R7 no mem", mreq_cnt, 0);
    chk("R7 no link", link_cnt, 0);
    chk("R7 invs", inv_cnt, 2);
    chk("R7 last target", last_inv, 9);
    chk("R7 pos", line_pos, 0);
    chk("R7 data", line_data, 4);
    chk("R7 fwd null", fwd_vld, 0);

    // R9 rejoin from Mid with self skip
    join_read(4'd8, 1'b1);
    send_pi(2'd0, 4'd3);
    chk("R5 head->mid", line_pos, 2);
    chk("R5 fresh kept", line_data, 2);
    mhv = 1; mhead = 4'd3;
    nxv[3] = 1; nxi[3] = 4'(SELF);
    run_op(1'b1);
    chk("R9 mem write", mreq_wr, 1);
    chk("R9 link dst", last_link, 3);
    chk("R9 invs", inv_cnt, 2);
    chk("R9 skip target", last_inv, 8);
    chk("R9 pos", line_pos, 0);
    chk("R9 data", line_data, 4);
    chk("R9 bwd null", bwd_vld, 0);

    // R6 / R11 invalidate reply held under back-pressure
    join_read(4'd8, 1'b1);
    po_ready = 0;
    send_pi(2'd1, 4'd7);
    chk("R6 ack valid", po_valid, 1);
    chk("R6 ack kind", po_kind, 2);
    chk("R6 ack dst", po_dst, 7);
    chk("R6 ack ptr vld", po_ptr_vld, 1);
    chk("R6 ack ptr", po_ptr, 8);
    chk("R6 data invalid", line_data, 0);
    chk("R6 fwd cleared", fwd_vld, 0);
    repeat (3) @(negedge clk);
    chk("R11 held valid", po_valid, 1);
    chk("R11 held dst", po_dst, 7);
    chk("R11 held ptr", po_ptr, 8);
    chk("R10 busy port", cpu_req_ready, 0);
    po_ready = 1;
    @(negedge clk);
    chk("R11 released", po_valid, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule